// File: doc/BRIEF.md
# Byte Lane Column Strobe Decoder

This block turns the transfer size code and the two low address bits of a 32-bit processor access into four active-low column strobes, one per byte-wide memory bank. A byte access strobes one bank. A halfword access strobes one aligned pair of banks. A word access strobes all four banks. On a sub-word store the processor copies the data across the whole bus, so these strobes alone limit the write to the addressed bytes.

A configuration input selects how byte addresses map to banks. In little-endian mode, byte address 0 uses the bank on data bits 7:0. In big-endian mode, byte address 0 uses the bank on data bits 31:24. A strobe-enable input marks the column-strobe phase. The decoded pattern is registered on the rising memory clock edge, so the strobes are timed from that clock. The reserved size code strobes nothing and raises an error flag.

Top module: `lane_strobe_decoder`

## Requirements
- R1: The size code `size_i` is decoded as follows: 2'b00 is byte, 2'b01 is halfword, 2'b10 is word and 2'b11 is reserved.
- R2: For a byte access in little-endian mode, exactly one strobe is driven low: `lane_n_o[addr_i]`. Strobe `lane_n_o[i]` covers data bits 8i+7:8i.
- R3: For a halfword access, `addr_i[0]` is ignored. In little-endian mode, `addr_i[1]`=0 drives strobes 1:0 low and `addr_i[1]`=1 drives strobes 3:2 low.
- R4: For a word access, both address bits are ignored and all four strobes are driven low.
- R5: With `big_endian_i`=1, the lane pattern is the mirror of the little-endian pattern: little-endian lane i becomes lane 3-i.
- R6: While `strobe_en_i` is low at a clock edge, all strobes are high and `size_err_o` is low after that edge, whatever the size and address inputs are.
- R7: When the reserved code is sampled with `strobe_en_i` high, all strobes are high and `size_err_o` is high for the following cycle only. The flag clears after the next edge unless the reserved code is sampled again.
- R8: Inputs are sampled on the rising edge of `clk`. The outputs change only after that edge and hold for the whole following cycle.
- R9: A synchronous active-low reset (`rst_n`=0 at an edge) sets all strobes high and `size_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; its rising edge samples the inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| size_i | input | 2 | Transfer size code; follows the address timing |
| addr_i | input | 2 | Low byte-address bits of the access |
| big_endian_i | input | 1 | 1 selects the big-endian lane mapping |
| strobe_en_i | input | 1 | Column-strobe phase qualifier; 0 keeps all strobes inactive |
| lane_n_o | output | 4 | Active-low per-bank column strobes; bit i covers data bits 8i+7:8i |
| size_err_o | output | 1 | High for one cycle after a reserved size code is sampled with the enable high |

## Verification
The bench sweeps every combination of enable, endian mode, size code and address. Sweeping all addresses for each size tells a decoder that really ignores the unaligned bits apart from one that leaks them into the lane choice. Sweeping both endian modes tells a true mirror apart from a shifted or unchanged mapping. Before each clock edge, the bench also checks that the outputs still show the previous pattern, which exposes a decoder that is not registered. Because the sweep order places a reserved code directly before a valid one, it shows whether the error flag lasts one cycle or sticks.

// File: rtl/lsd_pkg.sv
// Package: shared transfer size encoding for the byte lane strobe decoder.
// Assumes a two-bit size code that carries the same timing as the address.
package lsd_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/lsd_size_decode.sv
// Module: lsd_size_decode
// Turns size code and low address bits into a little-endian lane mask.
// Halfword ignores address bit 0; word ignores all address bits.
// Assumes LANES is a power of two, at least 2.
module lsd_size_decode #(
    parameter int LANES = 4,
    localparam int AW = $clog2(LANES)
) (
    input  lsd_pkg::xfer_size_e size,
    input  logic [AW-1:0]       addr,
    output logic [LANES-1:0]    le_mask,
    output logic                rsvd
);
    import lsd_pkg::*;

    logic [AW-1:0] pair_sel;

    // Purpose: halfword pair index, with address bit 0 dropped.
    assign pair_sel = addr >> 1;

    // Purpose: flag the reserved size code.
    assign rsvd = (size == SZ_RSVD);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            localparam logic [AW-1:0] LANE_IDX = AW'(g);
            localparam logic [AW-1:0] PAIR_IDX = AW'(g >> 1);
            // Purpose: decide whether lane g takes part in this access.
            always_comb begin
                unique case (size)
                    SZ_BYTE: le_mask[g] = (addr == LANE_IDX);
                    SZ_HALF: le_mask[g] = (pair_sel == PAIR_IDX);
                    SZ_WORD: le_mask[g] = 1'b1;
                    default: le_mask[g] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lsd_endian_map.sv
// Module: lsd_endian_map
// Mirrors the little-endian lane mask when big-endian mapping is chosen,
// so byte address 0 lands on the most significant bank.
module lsd_endian_map #(
    parameter int LANES = 4
) (
    input  logic             big_endian,
    input  logic [LANES-1:0] le_mask,
    output logic [LANES-1:0] lane_mask
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_map
            // Purpose: pick the straight or mirrored source lane.
            assign lane_mask[g] = big_endian ? le_mask[LANES-1-g] : le_mask[g];
        end
    endgenerate
endmodule

// File: rtl/lsd_strobe_reg.sv
// Module: lsd_strobe_reg
// Registers the lane mask as active-low strobes on the memory clock edge.
// The enable gates all strobes. Synchronous active-low reset.
module lsd_strobe_reg #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LANES-1:0] lane_mask,
    input  logic             rsvd,
    output logic [LANES-1:0] lane_n,
    output logic             err
);
    // Purpose: capture the gated, inverted lane pattern and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_n <= '1;
            err    <= 1'b0;
        end else begin
            lane_n <= enable ? ~lane_mask : '1;
            err    <= enable & rsvd;
        end
    end
endmodule

// File: rtl/lane_strobe_decoder.sv
// Module: lane_strobe_decoder (top)
// Chain: size decode -> endian mapping -> strobe register.
// Assumes size and address are stable around the sampling edge.
module lane_strobe_decoder #(
    parameter int LANES = 4,
    localparam int AW = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       size_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             big_endian_i,
    input  logic             strobe_en_i,
    output logic [LANES-1:0] lane_n_o,
    output logic             size_err_o
);
    import lsd_pkg::*;

    logic [LANES-1:0] le_mask;
    logic [LANES-1:0] lane_mask;
    logic             rsvd;

    lsd_size_decode #(.LANES(LANES)) u_dec (
        .size    (xfer_size_e'(size_i)),
        .addr    (addr_i),
        .le_mask (le_mask),
        .rsvd    (rsvd)
    );

    lsd_endian_map #(.LANES(LANES)) u_map (
        .big_endian (big_endian_i),
        .le_mask    (le_mask),
        .lane_mask  (lane_mask)
    );

    lsd_strobe_reg #(.LANES(LANES)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (strobe_en_i),
        .lane_mask (lane_mask),
        .rsvd      (rsvd),
        .lane_n    (lane_n_o),
        .err       (size_err_o)
    );
endmodule

// File: rtl/lsd_checker.sv
// Module: lsd_checker
// Clocked properties on the strobe decoder ports; bound to the top below.
module lsd_checker #(
    parameter int LANES = 4,
    localparam int AW = $clog2(LANES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       size_i,
    input logic [AW-1:0]    addr_i,
    input logic             big_endian_i,
    input logic             strobe_en_i,
    input logic [LANES-1:0] lane_n_o,
    input logic             size_err_o
);
    a_r2_byte_le_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_en_i && !big_endian_i && size_i == 2'b00)
        |=> (~lane_n_o == (LANES'(1) << $past(addr_i))));

    a_r3_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_en_i && size_i == 2'b01) |=> ($countones(~lane_n_o) == 2));

    a_r4_word_all: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_en_i && size_i == 2'b10) |=> (lane_n_o == '0));

    a_r5_byte_be_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_en_i && big_endian_i && size_i == 2'b00)
        |=> (~lane_n_o == (LANES'(1) << (AW'(LANES - 1) - $past(addr_i)))));

    a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_en_i |=> (lane_n_o == '1 && !size_err_o));

    a_r7_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_en_i && size_i == 2'b11) |=> (lane_n_o == '1 && size_err_o));

    a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_en_i && size_i == 2'b11) |=> !size_err_o);
endmodule

bind lane_strobe_decoder lsd_checker #(.LANES(LANES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .size_i       (size_i),
    .addr_i       (addr_i),
    .big_endian_i (big_endian_i),
    .strobe_en_i  (strobe_en_i),
    .lane_n_o     (lane_n_o),
    .size_err_o   (size_err_o)
);

// File: tb/lane_strobe_decoder_tb_top.sv
module lane_strobe_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] size_i;
    logic [1:0] addr_i;
    logic       big_endian_i;
    logic       strobe_en_i;
    logic [3:0] lane_n_o;
    logic       size_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    lane_strobe_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .size_i(size_i), .addr_i(addr_i),
        .big_endian_i(big_endian_i), .strobe_en_i(strobe_en_i),
        .lane_n_o(lane_n_o), .size_err_o(size_err_o)
    );

    // Expected strobes from R1-R6 rules, computed arithmetically.
    function automatic logic [3:0] exp_lanes(input logic en, input logic be,
                                             input logic [1:0] sz, input logic [1:0] a);
        logic [3:0] m;
        logic [3:0] r;
        case (sz)
            2'b00:   m = 4'b0001 << a;
            2'b01:   m = a[1] ? 4'b1100 : 4'b0011;
            2'b10:   m = 4'b1111;
            default: m = 4'b0000;
        endcase
        r = be ? {m[0], m[1], m[2], m[3]} : m;
        return en ? ~r : 4'b1111;
    endfunction

    task automatic check(input string req, input logic [3:0] exp_l, input logic exp_e);
        checks++;
        if (lane_n_o !== exp_l || size_err_o !== exp_e) begin
            errors++;
            $display("FAIL %s lane_n=%b err=%b expected lane_n=%b err=%b",
                     req, lane_n_o, size_err_o, exp_l, exp_e);
        end
    endtask

    initial begin
        logic [3:0] prev_l;
        logic       prev_e;
        string      tag;
        rst_n = 1'b0; size_i = 2'b10; addr_i = 2'b00;
        big_endian_i = 1'b0; strobe_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 reset", 4'b1111, 1'b0);
        rst_n = 1'b1;
        prev_l = 4'b1111; prev_e = 1'b0;
        for (int e = 0; e < 2; e++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int a = 0; a < 4; a++) begin
                        strobe_en_i  = e[0];
                        big_endian_i = b[0];
                        size_i       = s[1:0];
                        addr_i       = a[1:0];
                        #1;
                        check("R8 held before edge", prev_l, prev_e);
                        @(posedge clk); @(negedge clk);
                        if (e == 0)      tag = "R6 disabled";
                        else if (s == 3) tag = "R7 reserved";
                        else if (b == 1) tag = "R5 big-endian";
                        else if (s == 0) tag = "R2 byte";
                        else if (s == 1) tag = "R3 halfword";
                        else             tag = "R4 word";
                        prev_l = exp_lanes(e[0], b[0], s[1:0], a[1:0]);
                        prev_e = (e == 1) && (s == 3);
                        check({tag, " R1"}, prev_l, prev_e);
                    end
                end
            end
        end
        // R7: the flag lasts one cycle after a reserved code.
        strobe_en_i = 1'b1; big_endian_i = 1'b0; size_i = 2'b11; addr_i = 2'b01;
        @(posedge clk); @(negedge clk);
        check("R7 flag set", 4'b1111, 1'b1);
        size_i = 2'b00;
        @(posedge clk); @(negedge clk);
        check("R7 flag one cycle", 4'b1101, 1'b0);
        // R9: reset during an active word access.
        size_i = 2'b10; rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 reset mid-run", 4'b1111, 1'b0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule